// File: doc/BRIEF.md
# Hash-Based Queue Selector

This block picks a receive queue for each packet so that packets of one flow always land in the same queue, while different flows spread over a range of queues. For every input beat it forms a flow key from the parsed IPv4 addresses, the L4 ports and the IPsec SPI. It hashes that key with a 64-bit CRC, takes a shifted 24-bit slice of the hash, masks it to a power-of-two queue count and merges it with a queue base.

Configuration is one scheme: an enable, a field-select mask, two default words that stand in for absent headers, a queue base and a hash command word. The hash command word carries the shift, the queue-count mask and a symmetric flag. In symmetric mode both directions of a conversation give the same queue. The pipeline accepts one beat per clock and keeps a count of the queue IDs it has produced. Configuration is assumed to stay constant while beats are in flight.

Top module: `hash_queue_select`

## Requirements
- R1: A beat accepted with `in_valid` high while `cfg_enable` is high gives exactly one `out_valid` pulse two clock edges later. Beats may arrive on every cycle and produce outputs on every cycle, in order.
- R2: `cfg_fields` selects the key fields: bit 0 source address, bit 1 destination address, bit 2 source port, bit 3 destination port, bit 4 SPI. A field whose bit is clear enters the key as all zeros.
- R3: When `in_ip_ok` is low, both addresses are replaced by `cfg_dv0`. When `in_l4_ok` is low, the source port is replaced by `cfg_dv1[31:16]` and the destination port by `cfg_dv1[15:0]`. When `in_spi_ok` is low, the SPI is replaced by zero. These substitutions are made before field selection.
- R4: The 128-bit key is {source address, destination address, source port, destination port, SPI}, most significant first. The hash is a CRC-64 over it with polynomial 0x42F0E1EBA9EA3693, initial value zero, bits fed most significant first, and no reflection or final inversion.
- R5: The hash is shifted right by `cfg_hash_cmd[29:24]` (0 to 63), and the low 24 bits of the result form the slice. A shift of 0 uses the raw low 24 hash bits.
- R6: `cfg_hash_cmd[23:0]` holds the queue count minus one. `out_qid` equals `cfg_qbase` OR (slice AND that mask).
- R7: With `cfg_hash_cmd[30]` set, after substitution and selection, the smaller of the two addresses takes the source position and the larger the destination position. The two ports are ordered the same way. Swapping the directions of a flow then gives the same `out_qid`.
- R8: A beat presented while `cfg_enable` is low produces no `out_valid` and leaves `pkt_count` unchanged.
- R9: `pkt_count` rises by one in the cycle after each `out_valid` pulse and holds otherwise.
- R10: After reset, `out_valid` is low, `out_qid` is zero and `pkt_count` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Beat strobe |
| in_src_ip | input | 32 | IPv4 source address |
| in_dst_ip | input | 32 | IPv4 destination address |
| in_src_port | input | 16 | L4 source port |
| in_dst_port | input | 16 | L4 destination port |
| in_spi | input | 32 | IPsec SPI |
| in_ip_ok | input | 1 | Addresses are present |
| in_l4_ok | input | 1 | Ports are present |
| in_spi_ok | input | 1 | SPI is present |
| cfg_enable | input | 1 | Scheme enable |
| cfg_fields | input | 5 | Key field select |
| cfg_dv0 | input | 32 | Default address word |
| cfg_dv1 | input | 32 | Default port word (source high, destination low) |
| cfg_qbase | input | 24 | Queue base |
| cfg_hash_cmd | input | 31 | [30] symmetric, [29:24] shift, [23:0] count minus one |
| out_valid | output | 1 | Queue ID strobe |
| out_qid | output | 24 | Selected queue ID |
| pkt_count | output | 32 | Output count |

## Verification
A queue ID is due two rising edges after its beat is captured, and the count reflects it one edge later. The bench drives beats at falling edges and reads results at the falling edge that follows the second capturing edge. This keeps every check half a period away from any register update. A back-to-back burst checks that each of four beats appears in turn at that same two-edge distance. A sweep over field masks, presence flags, shift and count settings and the symmetric flag compares every ID with a CRC and slice model written in the bench. Disabled-scheme beats are checked by confirming that no strobe appears in the slot where it would be due and that the count stays the same.

// File: rtl/hqs_pkg.sv
// Shared types and the CRC-64 step for the hash queue selector.
// Assumes the key layout of the brief: addresses, ports, SPI, MSB first.
package hqs_pkg;
    localparam int KEY_W  = 128;
    localparam int HASH_W = 64;
    localparam logic [HASH_W-1:0] CRC_POLY = 64'h42F0E1EBA9EA3693;

    // Positions inside the field-select input
    localparam int FS_SRC_IP   = 0;
    localparam int FS_DST_IP   = 1;
    localparam int FS_SRC_PORT = 2;
    localparam int FS_DST_PORT = 3;
    localparam int FS_SPI      = 4;
    localparam int FS_W        = 5;

    // Positions inside the hash command word
    localparam int HC_SYM       = 30;
    localparam int HC_SHIFT_LSB = 24;
    localparam int HC_SHIFT_W   = 6;
    localparam int HC_W         = 31;

    typedef struct packed {
        logic [31:0] src_ip;
        logic [31:0] dst_ip;
        logic [15:0] src_port;
        logic [15:0] dst_port;
        logic [31:0] spi;
    } flow_key_t;
endpackage

// File: rtl/hqs_key_build.sv
// Assembles the flow key: substitutes defaults for absent headers,
// zeroes unselected fields, then optionally orders the pairs for
// symmetric hashing. Purely combinational.
module hqs_key_build
    import hqs_pkg::*;
(
    input  logic [31:0]   src_ip,
    input  logic [31:0]   dst_ip,
    input  logic [15:0]   src_port,
    input  logic [15:0]   dst_port,
    input  logic [31:0]   spi,
    input  logic          ip_ok,
    input  logic          l4_ok,
    input  logic          spi_ok,
    input  logic [FS_W-1:0] fields,
    input  logic [31:0]   dv0,
    input  logic [31:0]   dv1,
    input  logic          sym,
    output flow_key_t     key
);
    logic [31:0] a_s, a_d, s_v;
    logic [15:0] p_s, p_d;

    // Substitute defaults for missing headers, then apply the field select
    always_comb begin
        a_s = fields[FS_SRC_IP]   ? (ip_ok ? src_ip : dv0) : '0;
        a_d = fields[FS_DST_IP]   ? (ip_ok ? dst_ip : dv0) : '0;
        p_s = fields[FS_SRC_PORT] ? (l4_ok ? src_port : dv1[31:16]) : '0;
        p_d = fields[FS_DST_PORT] ? (l4_ok ? dst_port : dv1[15:0]) : '0;
        s_v = fields[FS_SPI]      ? (spi_ok ? spi : 32'h0) : '0;
    end

    // Order address and port pairs smaller-first when symmetric mode is on
    always_comb begin
        key.spi = s_v;
        if (sym && (a_s > a_d)) begin
            key.src_ip = a_d;
            key.dst_ip = a_s;
        end else begin
            key.src_ip = a_s;
            key.dst_ip = a_d;
        end
        if (sym && (p_s > p_d)) begin
            key.src_port = p_d;
            key.dst_port = p_s;
        end else begin
            key.src_port = p_s;
            key.dst_port = p_d;
        end
    end
endmodule

// File: rtl/hqs_crc64.sv
// Unrolled CRC over DATA_W bits, MSB first, zero initial value,
// no reflection. Combinational; the caller registers the result.
module hqs_crc64
    import hqs_pkg::*;
#(
    parameter int DATA_W = KEY_W
) (
    input  logic [DATA_W-1:0] data,
    output logic [HASH_W-1:0] crc
);
    logic [HASH_W-1:0] stage [DATA_W+1];

    assign stage[0] = '0;

    // One shift-and-reduce step per key bit, highest bit first
    for (genvar i = 0; i < DATA_W; i++) begin : g_step
        logic fb;
        assign fb = stage[i][HASH_W-1] ^ data[DATA_W-1-i];
        assign stage[i+1] = {stage[i][HASH_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end

    assign crc = stage[DATA_W];
endmodule

// File: rtl/hqs_slice_map.sv
// Maps a hash onto a queue ID: right shift, take the low QID_W bits,
// mask by (count - 1), OR with the base. Assumes the count is a power
// of two and the base is aligned to it for an even spread.
module hqs_slice_map
    import hqs_pkg::*;
#(
    parameter int QID_W = 24
) (
    input  logic [HASH_W-1:0]     hash,
    input  logic [HC_SHIFT_W-1:0] shift,
    input  logic [QID_W-1:0]      mask,
    input  logic [QID_W-1:0]      base,
    output logic [QID_W-1:0]      qid
);
    logic [QID_W-1:0] slice;

    // Shift the hash and keep the low slice
    assign slice = QID_W'(hash >> shift);
    // Merge the masked slice into the base
    assign qid   = base | (slice & mask);
endmodule

// File: rtl/hash_queue_select.sv
// Hash-based queue selector. Stage 1 registers the assembled key,
// stage 2 registers the hashed and mapped queue ID. One beat per cycle.
// Assumes configuration inputs are stable while beats are in flight.
module hash_queue_select
    import hqs_pkg::*;
#(
    parameter int QID_W = 24,
    parameter int CNT_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [31:0]         in_src_ip,
    input  logic [31:0]         in_dst_ip,
    input  logic [15:0]         in_src_port,
    input  logic [15:0]         in_dst_port,
    input  logic [31:0]         in_spi,
    input  logic                in_ip_ok,
    input  logic                in_l4_ok,
    input  logic                in_spi_ok,
    input  logic                cfg_enable,
    input  logic [FS_W-1:0]     cfg_fields,
    input  logic [31:0]         cfg_dv0,
    input  logic [31:0]         cfg_dv1,
    input  logic [QID_W-1:0]    cfg_qbase,
    input  logic [HC_W-1:0]     cfg_hash_cmd,
    output logic                out_valid,
    output logic [QID_W-1:0]    out_qid,
    output logic [CNT_W-1:0]    pkt_count
);
    flow_key_t         key_d, key_q;
    logic              key_v;
    logic [HASH_W-1:0] hash;
    logic [QID_W-1:0]  qid_d;

    hqs_key_build u_key (
        .src_ip  (in_src_ip),
        .dst_ip  (in_dst_ip),
        .src_port(in_src_port),
        .dst_port(in_dst_port),
        .spi     (in_spi),
        .ip_ok   (in_ip_ok),
        .l4_ok   (in_l4_ok),
        .spi_ok  (in_spi_ok),
        .fields  (cfg_fields),
        .dv0     (cfg_dv0),
        .dv1     (cfg_dv1),
        .sym     (cfg_hash_cmd[HC_SYM]),
        .key     (key_d)
    );

    // Stage 1: capture the key of an accepted beat
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_v <= 1'b0;
            key_q <= '0;
        end else begin
            key_v <= in_valid && cfg_enable;
            if (in_valid && cfg_enable) key_q <= key_d;
        end
    end

    hqs_crc64 #(.DATA_W(KEY_W)) u_crc (
        .data(key_q),
        .crc (hash)
    );

    hqs_slice_map #(.QID_W(QID_W)) u_map (
        .hash (hash),
        .shift(cfg_hash_cmd[HC_SHIFT_LSB +: HC_SHIFT_W]),
        .mask (cfg_hash_cmd[QID_W-1:0]),
        .base (cfg_qbase),
        .qid  (qid_d)
    );

    // Stage 2: register the queue ID and its strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_qid   <= '0;
        end else begin
            out_valid <= key_v;
            if (key_v) out_qid <= qid_d;
        end
    end

    // Count every produced queue ID
    always_ff @(posedge clk) begin
        if (!rst_n) pkt_count <= '0;
        else if (out_valid) pkt_count <= pkt_count + 1'b1;
    end
endmodule

// File: rtl/hqs_checker.sv
// Protocol checks for hash_queue_select, bound to every instance.
module hqs_checker #(
    parameter int QID_W = 24,
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             cfg_enable,
    input logic [QID_W-1:0] cfg_qbase,
    input logic [30:0]      cfg_hash_cmd,
    input logic             out_valid,
    input logic [QID_W-1:0] out_qid,
    input logic [CNT_W-1:0] pkt_count
);
    // R1: an enabled beat yields a strobe two edges later
    a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cfg_enable) |-> ##2 out_valid);

    // R8: a strobe only follows an enabled beat
    a_r8_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(in_valid, 2) && $past(cfg_enable, 2)));

    // R6: base bits always present in the ID
    a_r6_base_kept: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_qid & cfg_qbase) == cfg_qbase));

    // R6: no ID bit outside base and mask
    a_r6_within_range: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_qid & ~(cfg_qbase | cfg_hash_cmd[QID_W-1:0])) == '0));

    // R9: count steps after each strobe
    a_r9_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> (pkt_count == $past(pkt_count) + 1'b1));

    // R9: count holds without a strobe
    a_r9_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |=> $stable(pkt_count));
endmodule

bind hash_queue_select hqs_checker #(.QID_W(QID_W), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .cfg_enable  (cfg_enable),
    .cfg_qbase   (cfg_qbase),
    .cfg_hash_cmd(cfg_hash_cmd),
    .out_valid   (out_valid),
    .out_qid     (out_qid),
    .pkt_count   (pkt_count)
);

// File: tb/hash_queue_select_test.sv
// Self-checking bench: sweeps field masks, presence flags, shift and
// count settings and the symmetric flag against a model in the bench.
module hash_queue_select_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_src_ip = '0, in_dst_ip = '0, in_spi = '0;
    logic [15:0] in_src_port = '0, in_dst_port = '0;
    logic        in_ip_ok = 1'b0, in_l4_ok = 1'b0, in_spi_ok = 1'b0;
    logic        cfg_enable = 1'b0;
    logic [4:0]  cfg_fields = '0;
    logic [31:0] cfg_dv0 = 32'h0A0A0A0A, cfg_dv1 = 32'h0B0B0B0B;
    logic [23:0] cfg_qbase = '0;
    logic [30:0] cfg_hash_cmd = '0;
    logic        out_valid;
    logic [23:0] out_qid;
    logic [31:0] pkt_count;

    int total = 0;
    int bad = 0;
    int exp_count = 0;

    always #2.5 clk = ~clk;

    hash_queue_select uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_src_ip(in_src_ip), .in_dst_ip(in_dst_ip),
        .in_src_port(in_src_port), .in_dst_port(in_dst_port),
        .in_spi(in_spi), .in_ip_ok(in_ip_ok), .in_l4_ok(in_l4_ok),
        .in_spi_ok(in_spi_ok), .cfg_enable(cfg_enable),
        .cfg_fields(cfg_fields), .cfg_dv0(cfg_dv0), .cfg_dv1(cfg_dv1),
        .cfg_qbase(cfg_qbase), .cfg_hash_cmd(cfg_hash_cmd),
        .out_valid(out_valid), .out_qid(out_qid), .pkt_count(pkt_count)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Model of R2..R6: key, CRC-64, shift, mask, base
    function automatic logic [23:0] model(
        input logic [31:0] s, input logic [31:0] d,
        input logic [15:0] sp, input logic [15:0] dp, input logic [31:0] spi,
        input logic ipok, input logic l4ok, input logic spiok);
        logic [31:0] a0, a1, sv, t32;
        logic [15:0] p0, p1, t16;
        logic [127:0] k;
        logic [63:0] c;
        logic [63:0] sh;
        int n;
        a0 = ipok ? s : cfg_dv0;
        a1 = ipok ? d : cfg_dv0;
        p0 = l4ok ? sp : cfg_dv1[31:16];
        p1 = l4ok ? dp : cfg_dv1[15:0];
        sv = spiok ? spi : 32'h0;
        if (!cfg_fields[0]) a0 = 0;
        if (!cfg_fields[1]) a1 = 0;
        if (!cfg_fields[2]) p0 = 0;
        if (!cfg_fields[3]) p1 = 0;
        if (!cfg_fields[4]) sv = 0;
        if (cfg_hash_cmd[30]) begin
            if (a1 < a0) begin t32 = a0; a0 = a1; a1 = t32; end
            if (p1 < p0) begin t16 = p0; p0 = p1; p1 = t16; end
        end
        k = {a0, a1, p0, p1, sv};
        c = 64'h0;
        n = 127;
        while (n >= 0) begin
            if (c[63] ^ k[n]) c = (c << 1) ^ 64'h42F0E1EBA9EA3693;
            else c = c << 1;
            n--;
        end
        sh = c >> cfg_hash_cmd[29:24];
        return cfg_qbase | (sh[23:0] & cfg_hash_cmd[23:0]);
    endfunction

    task automatic drive(input logic [31:0] s, input logic [31:0] d,
                         input logic [15:0] sp, input logic [15:0] dp,
                         input logic [31:0] spi, input logic [2:0] ok);
        in_valid = 1'b1;
        in_src_ip = s; in_dst_ip = d; in_src_port = sp; in_dst_port = dp;
        in_spi = spi; in_ip_ok = ok[0]; in_l4_ok = ok[1]; in_spi_ok = ok[2];
    endtask

    // One beat, checked at the falling edge after the second capture edge
    task automatic one_beat(input string req, input logic [31:0] s, input logic [31:0] d,
                            input logic [15:0] sp, input logic [15:0] dp,
                            input logic [31:0] spi, input logic [2:0] ok,
                            output logic [23:0] got);
        logic [23:0] e;
        @(negedge clk);
        drive(s, d, sp, dp, spi, ok);
        e = model(s, d, sp, dp, spi, ok[0], ok[1], ok[2]);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        got = out_qid;
        if (cfg_enable) begin
            check({req, " strobe"}, {31'b0, out_valid}, 32'h1);
            check(req, {8'b0, out_qid}, {8'b0, e});
            exp_count++;
            @(negedge clk);
            check("R9 count", pkt_count, exp_count);
        end else begin
            check("R8 no strobe", {31'b0, out_valid}, 32'h0);
            @(negedge clk);
            check("R8 count held", pkt_count, exp_count);
        end
    endtask

    logic [30:0] hc_set [4];
    logic [23:0] qb_set [4];
    logic [4:0]  fs_set [4];

    initial begin
        logic [23:0] g1, g2;
        hc_set[0] = {1'b0, 6'd0,  24'h00000F}; qb_set[0] = 24'h123400;
        hc_set[1] = {1'b0, 6'd5,  24'h0000FF}; qb_set[1] = 24'hA00000;
        hc_set[2] = {1'b0, 6'd40, 24'h000000}; qb_set[2] = 24'h000777;
        hc_set[3] = {1'b0, 6'd63, 24'h0FFFFF}; qb_set[3] = 24'h300000;
        fs_set[0] = 5'b11111; fs_set[1] = 5'b00101;
        fs_set[2] = 5'b01010; fs_set[3] = 5'b10000;

        repeat (3) @(negedge clk);
        check("R10 valid", {31'b0, out_valid}, 32'h0);
        check("R10 qid", {8'b0, out_qid}, 32'h0);
        check("R10 count", pkt_count, 32'h0);
        rst_n = 1'b1;

        // R8: disabled scheme
        cfg_fields = 5'b11111; cfg_hash_cmd = hc_set[0]; cfg_qbase = qb_set[0];
        one_beat("R8", 32'h01020304, 32'h05060708, 16'd80, 16'd443, 32'h1, 3'b111, g1);

        // Sweep R2 R3 R4 R5 R6 R7
        cfg_enable = 1'b1;
        for (int f = 0; f < 4; f++)
            for (int h = 0; h < 4; h++)
                for (int sy = 0; sy < 2; sy++)
                    for (int ok = 0; ok < 8; ok++) begin
                        int ix;
                        ix = ((f * 4 + h) * 2 + sy) * 8 + ok;
                        cfg_fields = fs_set[f];
                        cfg_hash_cmd = hc_set[h] | (sy != 0 ? 31'h40000000 : 31'h0);
                        cfg_qbase = qb_set[h];
                        cfg_dv0 = 32'h0A0A0A0A + ix;
                        cfg_dv1 = 32'h0B0B0B0B ^ (ix << 3);
                        one_beat("R2 R3 R4 R5 R6 sweep",
                                 32'hC0A80001 + ix * 7919, 32'h0A000001 ^ (ix * 104729),
                                 16'(1000 + ix * 31), 16'(65000 - ix * 17),
                                 32'hDEAD0000 + ix, 3'(ok), g1);
                    end

        // R7: reversed flow maps to the same queue in symmetric mode
        cfg_fields = 5'b11111; cfg_qbase = 24'h400000;
        cfg_hash_cmd = {1'b1, 6'd3, 24'h0003FF};
        one_beat("R7 fwd", 32'h0A000005, 32'h0A000009, 16'd5000, 16'd80, 32'h0, 3'b011, g1);
        one_beat("R7 rev", 32'h0A000009, 32'h0A000005, 16'd80, 16'd5000, 32'h0, 3'b011, g2);
        check("R7 same queue", {8'b0, g2}, {8'b0, g1});

        // R1: back-to-back burst of four beats
        begin
            logic [23:0] ex [4];
            cfg_hash_cmd = {1'b0, 6'd7, 24'h00001F}; cfg_qbase = 24'h000100;
            for (int i = 0; i < 6; i++) begin
                @(negedge clk);
                if (i >= 2) begin
                    check("R1 burst strobe", {31'b0, out_valid}, 32'h1);
                    check("R1 burst qid", {8'b0, out_qid}, {8'b0, ex[i-2]});
                    exp_count++;
                end
                if (i < 4) begin
                    drive(32'h11110000 + i, 32'h22220000 - i, 16'(i), 16'(i * 3), 32'h5 + i, 3'b111);
                    ex[i] = model(32'h11110000 + i, 32'h22220000 - i, 16'(i), 16'(i * 3),
                                  32'h5 + i, 1'b1, 1'b1, 1'b1);
                end else in_valid = 1'b0;
            end
            @(negedge clk);
            check("R1 burst end", {31'b0, out_valid}, 32'h0);
            check("R9 burst count", pkt_count, exp_count);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule